// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block owns the program counter of a 64-bit core, together with a hidden return register. A decoder outside the block presents one control-flow request each cycle. The request carries an operation code, two comparison operands, a target address and an advance strobe. On every strobed cycle the block moves the program counter to the next sequential instruction, or redirects it to a new address. It reports whether it redirected, and whether the core has stopped.

Every instruction occupies a fixed 8 bytes, so both the sequential step and the saved link address are pc + 8. The link address goes into an internal return register. Software cannot read or write that register; it can only reach it by a return operation. Conditional branches compare the two operands directly, with no flag state between instructions. A halt freezes the unit until the next reset.

Top module: `bru_pc_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `pc` is 0, `halted` is 0 and `taken` is 0. The return register also clears to 0, so a return issued before any link loads `pc` with 0.
- R2: `op` codes are: 0 sequential, 1 halt, 2 jump, 3 call, 4 return, 5 equal, 6 not-equal, 7 less, 8 greater, 9 less-or-equal, 10 greater-or-equal. A strobed code 0 makes `pc` one cycle later the old `pc` + 8, with `taken` 0.
- R3: When `adv` is low, `pc` and `halted` hold and `taken` reads 0 on the next cycle, whatever `op` is.
- R4: A strobed jump (code 2) loads `pc` with `target` and sets `taken` to 1 for one cycle.
- R5: A strobed call (code 3) loads `pc` with `target`, sets `taken`, and saves the old `pc` + 8 in the return register.
- R6: A strobed return (code 4) loads `pc` with the return register and sets `taken`. A call followed by a return resumes at the instruction after the call.
- R7: Codes 5 and 6 load `pc` with `target` and set `taken` when `a` equals / differs from `b`. Otherwise `pc` steps by 8 and `taken` is 0.
- R8: Codes 7 to 10 compare `a` against `b` as signed two's-complement 64-bit values, and redirect as in R7 when `a` < b, `a` > b, `a` <= b or `a` >= b respectively.
- R9: A strobed halt (code 1) sets `halted`, keeps `pc` unchanged and gives `taken` 0. From then on, strobes of any code leave `pc` and `halted` unchanged until reset.
- R10: Codes 11 to 15 behave as sequential (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Advance strobe: apply this cycle's request |
| op | input | 4 | Control-flow operation code |
| opnd_a | input | 64 | First comparison operand |
| opnd_b | input | 64 | Second comparison operand |
| target | input | 64 | Redirect address |
| pc | output | 64 | Registered program counter |
| halted | output | 1 | Unit is stopped |
| taken | output | 1 | The last strobed request redirected `pc` |

## Verification
The bench sweeps every conditional code over operand pairs that are equal, ordered both ways, and straddle the sign boundary, such as -1 against 0 and the most negative against the most positive value. An unsigned comparator would take the wrong branch on those pairs. Another pass makes a call and then returns. A link that saved `pc` rather than `pc` + 8 would loop back onto the call itself. The bench also strobes redirects after a halt, where a halt that was not sticky would let `pc` move. It issues a return straight out of reset, which shows whether the return register is cleared.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    BOP_SEQ  = 4'd0,
    BOP_HALT = 4'd1,
    BOP_JUMP = 4'd2,
    BOP_CALL = 4'd3,
    BOP_RET  = 4'd4,
    BOP_EQ   = 4'd5,
    BOP_NE   = 4'd6,
    BOP_LT   = 4'd7,
    BOP_GT   = 4'd8,
    BOP_LE   = 4'd9,
    BOP_GE   = 4'd10
  } bop_e;
endpackage

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OP_W-1:0] op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            cond_true
);
  logic eq, lt;

  assign eq = (a == b);
  assign lt = ($signed(a) < $signed(b));

  always_comb begin
    case (op)
      BOP_EQ:  cond_true = eq;
      BOP_NE:  cond_true = !eq;
      BOP_LT:  cond_true = lt;
      BOP_GT:  cond_true = !lt && !eq;
      BOP_LE:  cond_true = lt || eq;
      BOP_GE:  cond_true = !lt;
      default: cond_true = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_next.sv
module bru_next
  import bru_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int INSN_BYTES = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic            cond_true,
  input  logic [XLEN-1:0] pc_cur,
  input  logic [XLEN-1:0] rp_cur,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] pc_nxt,
  output logic [XLEN-1:0] link_val,
  output logic            link_we,
  output logic            redirect,
  output logic            stop
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] seq_pc;
  assign seq_pc   = pc_cur + STEP;
  assign link_val = seq_pc;

  always_comb begin
    pc_nxt   = seq_pc;
    link_we  = 1'b0;
    redirect = 1'b0;
    stop     = 1'b0;
    case (op)
      BOP_HALT: begin
        pc_nxt = pc_cur;
        stop   = 1'b1;
      end
      BOP_JUMP: begin
        pc_nxt   = target;
        redirect = 1'b1;
      end
      BOP_CALL: begin
        pc_nxt   = target;
        redirect = 1'b1;
        link_we  = 1'b1;
      end
      BOP_RET: begin
        pc_nxt   = rp_cur;
        redirect = 1'b1;
      end
      BOP_EQ, BOP_NE, BOP_LT, BOP_GT, BOP_LE, BOP_GE: begin
        if (cond_true) begin
          pc_nxt   = target;
          redirect = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bru_pc_unit.sv
module bru_pc_unit
  import bru_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int INSN_BYTES = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] pc,
  output logic            halted,
  output logic            taken
);
  logic [XLEN-1:0] pc_q, rp_q, pc_nxt, link_val;
  logic            halt_q, taken_q, cond_true, link_we, redirect, stop;
  logic            fire;

  assign fire = adv && !halt_q;

  bru_cond #(.XLEN(XLEN)) u_cond (
    .op(op), .a(opnd_a), .b(opnd_b), .cond_true(cond_true)
  );

  bru_next #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_next (
    .op(op), .cond_true(cond_true), .pc_cur(pc_q), .rp_cur(rp_q),
    .target(target), .pc_nxt(pc_nxt), .link_val(link_val),
    .link_we(link_we), .redirect(redirect), .stop(stop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      rp_q    <= '0;
      halt_q  <= 1'b0;
      taken_q <= 1'b0;
    end else if (fire) begin
      pc_q    <= pc_nxt;
      halt_q  <= stop;
      taken_q <= redirect;
      if (link_we) rp_q <= link_val;
    end else begin
      taken_q <= 1'b0;
    end
  end

  assign pc     = pc_q;
  assign halted = halt_q;
  assign taken  = taken_q;

  localparam logic [XLEN-1:0] STEP_A = XLEN'(INSN_BYTES);

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (adv && !halted && op == BOP_SEQ) |=> (pc == $past(pc) + STEP_A) && !taken);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pc) && !taken);

  p_jump_load_r4: assert property (@(posedge clk) disable iff (rst)
    (adv && !halted && op == BOP_JUMP) |=> (pc == $past(target)) && taken);

  p_call_load_r5: assert property (@(posedge clk) disable iff (rst)
    (adv && !halted && op == BOP_CALL) |=> (pc == $past(target)) && taken);

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pc) && !taken);

  p_halt_enter_r9: assert property (@(posedge clk) disable iff (rst)
    (adv && !halted && op == BOP_HALT) |=> halted && $stable(pc));
endmodule

// File: tb/bru_pc_unit_tb.sv
module bru_pc_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [63:0] opnd_a = '0, opnd_b = '0, target = '0;
  logic [63:0] pc;
  logic        halted, taken;

  int n_cmp = 0;
  int n_bad = 0;

  logic [63:0] e_pc = '0, e_rp = '0;
  logic        e_halt = 1'b0, e_taken = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bru_pc_unit u_dut (
    .clk(clk), .rst(rst), .adv(adv), .op(op), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .target(target), .pc(pc), .halted(halted), .taken(taken)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic cond_of(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b);
    logic signed [63:0] sa, sb;
    sa = a; sb = b;
    case (o)
      4'd5:    return a == b;
      4'd6:    return a != b;
      4'd7:    return sa < sb;
      4'd8:    return sa > sb;
      4'd9:    return sa <= sb;
      4'd10:   return sa >= sb;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input string req, input logic v, input logic [3:0] o,
                      input logic [63:0] a, input logic [63:0] b, input logic [63:0] t);
    adv = v; op = o; opnd_a = a; opnd_b = b; target = t;
    e_taken = 1'b0;
    if (v && !e_halt) begin
      case (o)
        4'd1: e_halt = 1'b1;
        4'd2: begin e_pc = t; e_taken = 1'b1; end
        4'd3: begin e_rp = e_pc + 64'd8; e_pc = t; e_taken = 1'b1; end
        4'd4: begin e_pc = e_rp; e_taken = 1'b1; end
        4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10: begin
          if (cond_of(o, a, b)) begin e_pc = t; e_taken = 1'b1; end
          else e_pc = e_pc + 64'd8;
        end
        default: e_pc = e_pc + 64'd8;
      endcase
    end
    @(negedge clk);
    check({req, " pc"}, pc, e_pc);
    check({req, " taken"}, {63'd0, taken}, {63'd0, e_taken});
    check({req, " halted"}, {63'd0, halted}, {63'd0, e_halt});
  endtask

  task automatic do_reset();
    rst = 1'b1; adv = 1'b0;
    repeat (2) @(negedge clk);
    e_pc = '0; e_rp = '0; e_halt = 1'b0; e_taken = 1'b0;
    check("R1 reset pc", pc, 64'd0);
    check("R1 reset halted", {63'd0, halted}, 64'd0);
    check("R1 reset taken", {63'd0, taken}, 64'd0);
    rst = 1'b0;
  endtask

  initial begin
    logic [63:0] va [10];
    logic [63:0] vb [10];
    va[0] = 64'd0;                 vb[0] = 64'd0;
    va[1] = 64'd1;                 vb[1] = 64'd2;
    va[2] = 64'd2;                 vb[2] = 64'd1;
    va[3] = '1;                    vb[3] = 64'd0;
    va[4] = 64'd0;                 vb[4] = '1;
    va[5] = 64'h8000000000000000;  vb[5] = 64'h7fffffffffffffff;
    va[6] = 64'h7fffffffffffffff;  vb[6] = 64'h8000000000000000;
    va[7] = 64'h8000000000000000;  vb[7] = 64'h8000000000000000;
    va[8] = 64'h7fffffffffffffff;  vb[8] = 64'h7fffffffffffffff;
    va[9] = '1;                    vb[9] = 64'd1;

    @(negedge clk);
    do_reset();
    step("R2 seq", 1'b1, 4'd0, 0, 0, 64'hdead);
    step("R2 seq", 1'b1, 4'd0, 0, 0, 64'hdead);
    step("R3 idle jump", 1'b0, 4'd2, 0, 0, 64'h5000);
    step("R3 idle seq", 1'b0, 4'd0, 0, 0, 0);
    step("R1 R6 return from reset", 1'b1, 4'd4, 0, 0, 64'h7000);
    for (int c = 11; c < 16; c++) step("R10 unused code", 1'b1, 4'(c), 1, 1, 64'h9000);
    step("R4 jump", 1'b1, 4'd2, 0, 0, 64'h1000);
    step("R5 call", 1'b1, 4'd3, 0, 0, 64'h4000);
    step("R2 seq in callee", 1'b1, 4'd0, 0, 0, 0);
    step("R6 return after call", 1'b1, 4'd4, 0, 0, 64'h2222);
    step("R5 call nested", 1'b1, 4'd3, 0, 0, 64'h6000);
    step("R6 return again", 1'b1, 4'd4, 0, 0, 0);
    for (int o = 5; o <= 10; o++) begin
      for (int i = 0; i < 10; i++) begin
        step((o < 7) ? "R7 equality branch" : "R8 signed branch",
             1'b1, 4'(o), va[i], vb[i], 64'h10000 + 64'(o * 256 + i * 16));
      end
    end
    step("R9 halt", 1'b1, 4'd1, 0, 0, 64'h3000);
    step("R9 jump after halt", 1'b1, 4'd2, 0, 0, 64'h3000);
    step("R9 call after halt", 1'b1, 4'd3, 0, 0, 64'h3100);
    step("R9 seq after halt", 1'b1, 4'd0, 0, 0, 0);
    step("R9 beq after halt", 1'b1, 4'd5, 0, 0, 64'h3200);
    do_reset();
    step("R1 R6 return after second reset", 1'b1, 4'd4, 0, 0, 64'h1);
    step("R2 seq after reset", 1'b1, 4'd0, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule